// File: doc/BRIEF.md
# I2C Serial Clock Phase Generator

This block produces the serial clock waveform of an I2C master from the functional clock. The functional clock first passes through a programmable prescaler, which divides it by (prescale + 1) to form an internal time base. The clock is then held low for (low count + 7) time-base periods and released high for (high count + 5) time-base periods, and this repeats. The two fixed offsets always apply, so the bus rate is fclk / ((prescale+1) * (low + 7 + high + 5)). For example, a 48 MHz functional clock with prescale 1, low 111 and high 117 gives 100 kHz.

Software supplies three 16-bit configuration words and a high-speed mode bit. The normal low and high counts sit in bits [7:0] of their words, and the high-speed counts sit in bits [15:8] of the same words. The high-speed counts are used only when the mode bit is set. The surrounding byte engine reads `scl_drive_low` as a request to pull the line low, and uses `phase_tick` to place data changes and sampling points. A read-back output reports the total division of the configuration currently in force.

Configuration is captured only at the start of each low phase, so a phase that is already running is never cut short. When `enable` is low, the line is released and all counting stops.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, `scl_drive_low` and `phase_tick` are 0 from the first clock after `enable` was sampled low. After reset they are also 0.
- R2: Each low phase lasts (P+1)*(L+7) clock cycles. P is `cfg_prescale[7:0]`, and bits [15:8] of `cfg_prescale` have no effect.
- R3: Each high phase lasts (P+1)*(H+5) clock cycles.
- R4: With `cfg_hs_mode`=0, L and H come from bits [7:0] of `cfg_scl_low` and `cfg_scl_high`. With `cfg_hs_mode`=1, they come from bits [15:8] of the same words.
- R5: `phase_tick` is 1 for exactly one cycle, the first cycle of every low phase and of every high phase, and is 0 at all other times.
- R6: When `enable` is sampled 1 while the block is idle, a low phase begins in the next cycle with all counts starting from zero. Re-enabling therefore always begins a full-length low phase.
- R7: A configuration change made during a period does not alter that period. The new values apply from the next low phase onward.
- R8: `div_readback` equals (P+1)*(L+7+H+5) for the configuration in force. While the block is disabled, it follows the inputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run control; low releases the line and clears the counters |
| cfg_prescale | input | 16 | Prescale word; only bits [7:0] are used |
| cfg_scl_low | input | 16 | Low counts: normal mode in [7:0], high-speed mode in [15:8] |
| cfg_scl_high | input | 16 | High counts: normal mode in [7:0], high-speed mode in [15:8] |
| cfg_hs_mode | input | 1 | Selects the high-speed count bytes |
| scl_drive_low | output | 1 | Request to pull the serial clock low |
| phase_tick | output | 1 | One-cycle pulse at the start of each phase |
| div_readback | output | 19 | Total functional-clock cycles per bus period |

## Verification
The bench builds the block with its default parameters: 16-bit words and 8-bit fields. With these values both count bytes and the 8-bit prescale are fully present. Random trials draw small prescale values and counts while filling the unused prescale bits with noise. Directed trials cover the all-zero minimum of 7 and 5 time-base periods, counts of 255 in both bytes, a switch into high-speed mode in the middle of a period, and disabling the block in the middle of either phase.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_t;

  localparam int LOW_OFS  = 7;
  localparam int HIGH_OFS = 5;
endpackage

// File: rtl/scl_field_select.sv
module scl_field_select #(
  parameter int CFG_W = 16,
  parameter int FLD_W = 8,
  parameter int LEN_W = FLD_W + 1
) (
  input  logic [CFG_W-1:0] word_low,
  input  logic [CFG_W-1:0] word_high,
  input  logic             hs_mode,
  output logic [LEN_W-1:0] len_low,
  output logic [LEN_W-1:0] len_high
);
  import scl_timing_pkg::*;

  logic [CFG_W-1:0] words [2];
  logic [LEN_W-1:0] lens  [2];

  assign words[0] = word_low;
  assign words[1] = word_high;

  for (genvar g = 0; g < 2; g++) begin : g_phase
    localparam int OFS = (g == 0) ? LOW_OFS : HIGH_OFS;
    logic [FLD_W-1:0] fld;
    assign fld    = hs_mode ? words[g][2*FLD_W-1:FLD_W] : words[g][FLD_W-1:0];
    assign lens[g] = LEN_W'(fld) + LEN_W'(OFS);
  end

  assign len_low  = lens[0];
  assign len_high = lens[1];
endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] limit,
  output logic             qtick
);
  logic [PSC_W-1:0] pc;

  assign qtick = run && (pc == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc <= '0;
    else if (!run)   pc <= '0;
    else if (qtick)  pc <= '0;
    else             pc <= pc + 1'b1;
  end

  assert_pc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc <= limit);
  assert_pc_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pc == '0);
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int PSC_W = 8,
  parameter int LEN_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             qtick,
  input  logic [PSC_W-1:0] in_psc,
  input  logic [LEN_W-1:0] in_low,
  input  logic [LEN_W-1:0] in_high,
  output logic [PSC_W-1:0] act_psc,
  output logic [LEN_W-1:0] act_low,
  output logic [LEN_W-1:0] act_high,
  output logic             running,
  output logic             scl_low,
  output logic             tick
);
  import scl_timing_pkg::*;

  scl_phase_t       state;
  logic [LEN_W-1:0] cnt;
  logic             last_low, last_high;

  assign last_low  = qtick && (cnt == act_low  - LEN_W'(1));
  assign last_high = qtick && (cnt == act_high - LEN_W'(1));
  assign running   = enable && (state != PH_IDLE);
  assign scl_low   = (state == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      tick     <= 1'b0;
      act_psc  <= '0;
      act_low  <= '0;
      act_high <= '0;
    end else if (!enable) begin
      state    <= PH_IDLE;
      cnt      <= '0;
      tick     <= 1'b0;
      act_psc  <= in_psc;
      act_low  <= in_low;
      act_high <= in_high;
    end else begin
      tick <= 1'b0;
      unique case (state)
        PH_IDLE: begin
          state    <= PH_LOW;
          cnt      <= '0;
          tick     <= 1'b1;
          act_psc  <= in_psc;
          act_low  <= in_low;
          act_high <= in_high;
        end
        PH_LOW: begin
          if (last_low) begin
            state <= PH_HIGH;
            cnt   <= '0;
            tick  <= 1'b1;
          end else if (qtick) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (last_high) begin
            state    <= PH_LOW;
            cnt      <= '0;
            tick     <= 1'b1;
            act_psc  <= in_psc;
            act_low  <= in_low;
            act_high <= in_high;
          end else if (qtick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assert_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_IDLE && enable) |=> (state == PH_LOW && tick && cnt == '0));
  assert_tick_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> state != $past(state));
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOW && enable) |=> $stable(act_low) && $stable(act_high) && $stable(act_psc));
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_HIGH) |-> cnt < act_high);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PH_LOW) |-> cnt < act_low);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CFG_W = 16,
  parameter int FLD_W = 8,
  localparam int PSC_W = FLD_W,
  localparam int LEN_W = FLD_W + 1,
  localparam int DIV_W = (PSC_W + 1) + (LEN_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CFG_W-1:0] cfg_prescale,
  input  logic [CFG_W-1:0] cfg_scl_low,
  input  logic [CFG_W-1:0] cfg_scl_high,
  input  logic             cfg_hs_mode,
  output logic             scl_drive_low,
  output logic             phase_tick,
  output logic [DIV_W-1:0] div_readback
);
  logic [LEN_W-1:0] sel_low, sel_high;
  logic [LEN_W-1:0] act_low, act_high;
  logic [PSC_W-1:0] act_psc;
  logic             qtick, running;
  logic             unused_psc_hi;

  assign unused_psc_hi = ^cfg_prescale[CFG_W-1:PSC_W];

  scl_field_select #(.CFG_W(CFG_W), .FLD_W(FLD_W), .LEN_W(LEN_W)) i_sel (
    .word_low (cfg_scl_low),
    .word_high(cfg_scl_high),
    .hs_mode  (cfg_hs_mode),
    .len_low  (sel_low),
    .len_high (sel_high)
  );

  scl_prescaler #(.PSC_W(PSC_W)) i_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (running),
    .limit(act_psc),
    .qtick(qtick)
  );

  scl_phase_seq #(.PSC_W(PSC_W), .LEN_W(LEN_W)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .qtick   (qtick),
    .in_psc  (cfg_prescale[PSC_W-1:0]),
    .in_low  (sel_low),
    .in_high (sel_high),
    .act_psc (act_psc),
    .act_low (act_low),
    .act_high(act_high),
    .running (running),
    .scl_low (scl_drive_low),
    .tick    (phase_tick)
  );

  logic [PSC_W:0] psc_div;
  logic [LEN_W:0] sum_len;
  assign psc_div      = {1'b0, act_psc} + 1'b1;
  assign sum_len      = {1'b0, act_low} + {1'b0, act_high};
  assign div_readback = DIV_W'(psc_div) * DIV_W'(sum_len);

  assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_drive_low && !phase_tick));
  assert_tick_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && scl_drive_low != $past(scl_drive_low)) |-> phase_tick);
endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] cfg_prescale = '0, cfg_scl_low = '0, cfg_scl_high = '0;
  logic        cfg_hs_mode = 1'b0;
  logic        scl_drive_low, phase_tick;
  logic [18:0] div_readback;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_prescale(cfg_prescale), .cfg_scl_low(cfg_scl_low),
    .cfg_scl_high(cfg_scl_high), .cfg_hs_mode(cfg_hs_mode),
    .scl_drive_low(scl_drive_low), .phase_tick(phase_tick),
    .div_readback(div_readback)
  );

  function automatic int fld(input logic [15:0] w, input logic hs);
    return hs ? int'(w[15:8]) : int'(w[7:0]);
  endfunction
  function automatic int low_len(input logic [15:0] p, l, input logic hs);
    return (int'(p[7:0]) + 1) * (fld(l, hs) + 7);
  endfunction
  function automatic int high_len(input logic [15:0] p, h, input logic hs);
    return (int'(p[7:0]) + 1) * (fld(h, hs) + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // Two full periods: the first with config A, the second with config B,
  // which is applied during the first low phase (R7).
  task automatic trial(input logic [15:0] pa, la, ha, input logic hsa,
                       input logic [15:0] pb, lb, hb, input logic hsb);
    int la_n, ha_n, lb_n, hb_n, pos;
    bit exp_low, exp_tick;
    longint exp_div;
    @(negedge clk);
    cfg_prescale = pa; cfg_scl_low = la; cfg_scl_high = ha; cfg_hs_mode = hsa;
    enable = 1'b1;
    la_n = low_len(pa, la, hsa); ha_n = high_len(pa, ha, hsa);
    lb_n = low_len(pb, lb, hsb); hb_n = high_len(pb, hb, hsb);
    for (int i = 0; i < la_n + ha_n + lb_n + hb_n; i++) begin
      @(negedge clk);
      if (i < la_n + ha_n) begin
        pos = i;
        exp_low = pos < la_n;
        exp_tick = (pos == 0) || (pos == la_n);
        exp_div = la_n + ha_n;
      end else begin
        pos = i - la_n - ha_n;
        exp_low = pos < lb_n;
        exp_tick = (pos == 0) || (pos == lb_n);
        exp_div = lb_n + hb_n;
      end
      chk(scl_drive_low == exp_low, "R2/R3/R4/R7 scl_drive_low", scl_drive_low, exp_low);
      chk(phase_tick == exp_tick, "R5/R6 phase_tick", phase_tick, exp_tick);
      chk(div_readback == exp_div, "R8 div_readback", div_readback, exp_div);
      if (i == 0) begin
        cfg_prescale = pb; cfg_scl_low = lb; cfg_scl_high = hb; cfg_hs_mode = hsb;
      end
    end
    enable = 1'b0;
    @(negedge clk);
    chk(!scl_drive_low && !phase_tick, "R1 released after disable",
        {scl_drive_low, phase_tick}, 0);
  endtask

  // Disable part-way through a phase; check the line is released at once.
  task automatic cut_short(input int after);
    @(negedge clk);
    cfg_prescale = 16'h0001; cfg_scl_low = 16'h0004; cfg_scl_high = 16'h0003;
    cfg_hs_mode = 1'b0; enable = 1'b1;
    repeat (after) @(negedge clk);
    enable = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!scl_drive_low && !phase_tick, "R1 released mid-phase",
          {scl_drive_low, phase_tick}, 0);
    end
  endtask

  function automatic logic [15:0] rnd_word();
    return {8'($urandom_range(0, 40)), 8'($urandom_range(0, 40))};
  endfunction

  initial begin
    while (1) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog R6 actual=%0d expected=done", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] p1, l1, h1, p2, l2, h2;
    logic hs1, hs2;
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    chk(!scl_drive_low && !phase_tick, "R1 reset state", {scl_drive_low, phase_tick}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_drive_low && !phase_tick, "R1 after reset", {scl_drive_low, phase_tick}, 0);

    // R8: idle read-back follows the inputs one clock later.
    cfg_prescale = 16'hA501; cfg_scl_low = 16'h206F; cfg_scl_high = 16'h1075; cfg_hs_mode = 1'b0;
    @(negedge clk);
    chk(div_readback == 19'd480, "R8 idle read-back std", div_readback, 480);
    cfg_hs_mode = 1'b1;
    @(negedge clk);
    chk(div_readback == 19'd2 * (32 + 7 + 16 + 5), "R8 idle read-back hs", div_readback, 120);

    // Directed corners: minimum counts, largest counts, mode switch mid-period.
    trial(16'h0000, 16'h0000, 16'h0000, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0);
    trial(16'hFF00, 16'h00FF, 16'h00FF, 1'b0, 16'h0002, 16'h0003, 16'h0001, 1'b0);
    trial(16'h0001, 16'h0A02, 16'h0605, 1'b0, 16'h0001, 16'h0A02, 16'h0605, 1'b1);
    trial(16'h0000, 16'h0300, 16'h0100, 1'b1, 16'h0003, 16'h0300, 16'h0100, 1'b0);

    cut_short(3);
    cut_short(15);
    // Re-enable after a cut: must start a fresh full period (R6).
    trial(16'h0001, 16'h0004, 16'h0003, 1'b0, 16'h0001, 16'h0004, 16'h0003, 1'b0);

    for (int t = 0; t < 12; t++) begin
      p1 = {8'($urandom()), 8'($urandom_range(0, 3))};
      p2 = {8'($urandom()), 8'($urandom_range(0, 3))};
      l1 = rnd_word(); h1 = rnd_word(); l2 = rnd_word(); h2 = rnd_word();
      hs1 = 1'($urandom()); hs2 = 1'($urandom());
      trial(p1, l1, h1, hs1, p2, l2, h2, hs2);
    end
    finish_run();
  end
endmodule